// File: doc/BRIEF.md
# Display RAM Byte Access Controller

This block connects a decoded host byte port to a byte-wide display memory. The memory has a fixed number of columns and a small number of pages, and the last page holds the icon row. The block keeps the page register, the column register and a single-byte holding latch. Every host strobe is classified by its register-select and direction bits as one of four accesses: command write, status read, data write or data read. The block then produces the memory address, write enable, read enable and write data, and it returns read bytes on a registered output.

Reads go through the holding latch. A data read returns the byte that the latch already holds, and then reloads the latch from memory at the address in use when the read was made. As a result, the first read after any address change returns stale data and acts as a dummy read. A data write also loads the latch, and the byte is committed to memory on the next clock cycle. The block also has a read-modify-write mode. In this mode, data reads leave the column in place and data writes advance it. When the mode ends, the column returns to the value it held on entry.

Top module: `dispram_port`

## Requirements
- R1: After synchronous reset, page and column are 0, the holding latch and `rdata` are 0x00, read-modify-write mode is off, and `ram_we` is low.
- R2: The command byte `1011_pppp` (rs=0, rd=0) loads the page with `pppp`. A value of PAGES or more is ignored and leaves the page unchanged.
- R3: The command byte `0001_0hhh` loads the column bits above bit 3 from the low bits of `hhh`. The command byte `0000_llll` loads column bits 3..0. Each of these commands leaves the other part of the column unchanged.
- R4: A data write (rs=1, rd=0) captures `wdata` in the holding latch. In the following cycle, `ram_we` is high for exactly one cycle, with `ram_wdata` equal to that byte and `ram_addr` equal to `{page, column}` as they were at the strobe.
- R5: A data read (rs=1, rd=1) places the holding latch contents on `rdata` in the cycle after the strobe. It drives `ram_re` during the strobe at the current `{page, column}`, and the latch takes the memory's reply one cycle later. The first read after an address change is therefore a dummy read.
- R6: Outside read-modify-write mode, each data write or data read advances the column by one. Column COLS-1 advances to 0, and the page does not change.
- R7: A status read (rs=0, rd=1) returns `stat_bits` on `rdata` in the cycle after the strobe, with bit 7 down to bit 0 meaning busy, column direction, display off, reset in progress, power save, icon only, reverse and all-lit. A status read leaves the column and the holding latch unchanged.
- R8: The command byte 0xE0 saves the column and enters read-modify-write mode. In this mode, data reads leave the column unchanged and data writes still advance it. A second 0xE0 while the mode is active is ignored.
- R9: While read-modify-write mode is active, both column set commands are ignored. The page set command is still accepted.
- R10: The command byte 0xEE restores the saved column and leaves read-modify-write mode. Outside the mode, 0xEE has no effect.
- R11: Any other command byte leaves the page, the column and the mode unchanged.
- R12: Host strobes are at least two cycles apart. This is a usage rule, and the checker watches for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb | input | 1 | One-cycle host access strobe |
| rs | input | 1 | 0: command/status, 1: display data |
| rd | input | 1 | 1: read, 0: write |
| wdata | input | 8 | Host write byte |
| stat_bits | input | 8 | Status flags returned by a status read |
| rdata | output | 8 | Registered host read byte |
| ram_addr | output | clog2(PAGES)+clog2(COLS) | Memory byte address {page, column} |
| ram_we | output | 1 | Memory write enable |
| ram_re | output | 1 | Memory read enable (reply one cycle later) |
| ram_wdata | output | 8 | Memory write byte |
| ram_rdata | input | 8 | Memory read reply |

## Verification
The bench builds the block with 32 columns and 9 pages. At that size it can write and read back every byte of every page, including the icon page. Every column sweep therefore reaches the wrap from column 31 to column 0, and with a 5-bit column the upper-bits column command still has a field of its own. All 256 status values are passed through. The read-modify-write sequences cover the save and restore of the column, a second entry command, a column set that is ignored and a page change made inside the mode, and each result is confirmed through later dummy-read and read pairs.

// File: rtl/dispram_pkg.sv
package dispram_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PAGE,
        OP_COL_HI,
        OP_COL_LO,
        OP_RMW_ON,
        OP_RMW_OFF
    } cmd_op_e;

    typedef enum logic [1:0] {
        ACC_CMD,
        ACC_STAT,
        ACC_DWR,
        ACC_DRD
    } acc_kind_e;

    localparam logic [7:0] BYTE_RMW_ON  = 8'hE0;
    localparam logic [7:0] BYTE_RMW_OFF = 8'hEE;

    function automatic cmd_op_e decode_cmd(input logic [7:0] b);
        cmd_op_e op;
        if (b == BYTE_RMW_ON)            op = OP_RMW_ON;
        else if (b == BYTE_RMW_OFF)      op = OP_RMW_OFF;
        else if (b[7:4] == 4'b1011)      op = OP_PAGE;
        else if (b[7:3] == 5'b00010)     op = OP_COL_HI;
        else if (b[7:4] == 4'b0000)      op = OP_COL_LO;
        else                             op = OP_NONE;
        return op;
    endfunction

    function automatic acc_kind_e classify(input logic sel_data, input logic is_read);
        acc_kind_e k;
        case ({sel_data, is_read})
            2'b00:   k = ACC_CMD;
            2'b01:   k = ACC_STAT;
            2'b10:   k = ACC_DWR;
            default: k = ACC_DRD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/dispram_cmd_dec.sv
module dispram_cmd_dec
    import dispram_pkg::*;
(
    input  logic       stb,
    input  logic       rs,
    input  logic       rd,
    input  logic [7:0] wdata,
    output logic       cmd_stb,
    output logic       stat_stb,
    output logic       dwr_stb,
    output logic       drd_stb,
    output cmd_op_e    op
);
    acc_kind_e kind;

    always_comb begin
        kind     = classify(rs, rd);
        op       = decode_cmd(wdata);
        cmd_stb  = stb && (kind == ACC_CMD);
        stat_stb = stb && (kind == ACC_STAT);
        dwr_stb  = stb && (kind == ACC_DWR);
        drd_stb  = stb && (kind == ACC_DRD);
    end
endmodule

// File: rtl/dispram_addr_ctrl.sv
module dispram_addr_ctrl
    import dispram_pkg::*;
#(
    parameter int COLS  = 128,
    parameter int PAGES = 9,
    localparam int CW   = $clog2(COLS),
    localparam int PW   = $clog2(PAGES),
    localparam int HW   = CW - 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_stb,
    input  cmd_op_e       op,
    input  logic [3:0]    arg,
    input  logic          dwr_stb,
    input  logic          drd_stb,
    output logic [PW-1:0] page,
    output logic [CW-1:0] col,
    output logic          rmw
);
    logic [CW-1:0] save_col;
    logic [CW-1:0] next_col;
    logic          advance;

    always_comb begin
        next_col = (col == CW'(COLS - 1)) ? '0 : col + 1'b1;
        advance  = dwr_stb || (drd_stb && !rmw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page     <= '0;
            col      <= '0;
            save_col <= '0;
            rmw      <= 1'b0;
        end else if (cmd_stb) begin
            case (op)
                OP_PAGE:    if (int'(arg) < PAGES) page <= arg[PW-1:0];
                OP_COL_HI:  if (!rmw) col[CW-1:4] <= arg[HW-1:0];
                OP_COL_LO:  if (!rmw) col[3:0] <= arg;
                OP_RMW_ON:  if (!rmw) begin
                                save_col <= col;
                                rmw      <= 1'b1;
                            end
                OP_RMW_OFF: if (rmw) begin
                                col <= save_col;
                                rmw <= 1'b0;
                            end
                default: ;
            endcase
        end else if (advance) begin
            col <= next_col;
        end
    end
endmodule

// File: rtl/dispram_holder.sv
module dispram_holder #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dwr_stb,
    input  logic          drd_stb,
    input  logic          stat_stb,
    input  logic [7:0]    wdata,
    input  logic [7:0]    stat_bits,
    input  logic [AW-1:0] cur_addr,
    input  logic [7:0]    ram_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic          ram_re,
    output logic [7:0]    ram_wdata,
    output logic [7:0]    rdata,
    output logic [7:0]    hold_q
);
    logic          wr_pend;
    logic          rd_pend;
    logic [AW-1:0] wr_addr;

    always_comb begin
        ram_re    = drd_stb;
        ram_we    = wr_pend;
        ram_wdata = hold_q;
        ram_addr  = wr_pend ? wr_addr : cur_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend <= 1'b0;
            rd_pend <= 1'b0;
            wr_addr <= '0;
            hold_q  <= '0;
            rdata   <= '0;
        end else begin
            wr_pend <= dwr_stb;
            rd_pend <= drd_stb;
            if (dwr_stb) begin
                hold_q  <= wdata;
                wr_addr <= cur_addr;
            end else if (rd_pend) begin
                hold_q <= ram_rdata;
            end
            if (drd_stb)       rdata <= hold_q;
            else if (stat_stb) rdata <= stat_bits;
        end
    end
endmodule

// File: rtl/dispram_port.sv
module dispram_port
    import dispram_pkg::*;
#(
    parameter int COLS  = 128,
    parameter int PAGES = 9
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   stb,
    input  logic                                   rs,
    input  logic                                   rd,
    input  logic [7:0]                             wdata,
    input  logic [7:0]                             stat_bits,
    output logic [7:0]                             rdata,
    output logic [$clog2(PAGES)+$clog2(COLS)-1:0]  ram_addr,
    output logic                                   ram_we,
    output logic                                   ram_re,
    output logic [7:0]                             ram_wdata,
    input  logic [7:0]                             ram_rdata
);
    localparam int CW = $clog2(COLS);
    localparam int PW = $clog2(PAGES);
    localparam int AW = PW + CW;

    logic          cmd_stb, stat_stb, dwr_stb, drd_stb;
    cmd_op_e       op;
    logic [PW-1:0] page;
    logic [CW-1:0] col;
    logic          rmw;
    logic [7:0]    hold_q;

    dispram_cmd_dec u_dec (
        .stb      (stb),
        .rs       (rs),
        .rd       (rd),
        .wdata    (wdata),
        .cmd_stb  (cmd_stb),
        .stat_stb (stat_stb),
        .dwr_stb  (dwr_stb),
        .drd_stb  (drd_stb),
        .op       (op)
    );

    dispram_addr_ctrl #(.COLS(COLS), .PAGES(PAGES)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .cmd_stb (cmd_stb),
        .op      (op),
        .arg     (wdata[3:0]),
        .dwr_stb (dwr_stb),
        .drd_stb (drd_stb),
        .page    (page),
        .col     (col),
        .rmw     (rmw)
    );

    dispram_holder #(.AW(AW)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .dwr_stb   (dwr_stb),
        .drd_stb   (drd_stb),
        .stat_stb  (stat_stb),
        .wdata     (wdata),
        .stat_bits (stat_bits),
        .cur_addr  ({page, col}),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_wdata (ram_wdata),
        .rdata     (rdata),
        .hold_q    (hold_q)
    );
endmodule

// File: rtl/dispram_port_chk.sv
module dispram_port_chk #(
    parameter int COLS  = 128,
    parameter int PAGES = 9,
    localparam int CW   = $clog2(COLS),
    localparam int PW   = $clog2(PAGES)
) (
    input logic          clk,
    input logic          rst,
    input logic          stb,
    input logic          rs,
    input logic          rd,
    input logic [7:0]    stat_bits,
    input logic [7:0]    rdata,
    input logic          ram_we,
    input logic [PW-1:0] page,
    input logic [CW-1:0] col,
    input logic          rmw,
    input logic [7:0]    hold_q
);
    assert_page_range_R2: assert property (@(posedge clk) disable iff (rst)
        int'(page) < PAGES);

    assert_wr_commit_R4: assert property (@(posedge clk) disable iff (rst)
        (stb && rs && !rd) |=> ram_we);

    assert_we_source_R4: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(stb && rs && !rd));

    assert_rd_from_holder_R5: assert property (@(posedge clk) disable iff (rst)
        (stb && rs && rd) |=> (rdata == $past(hold_q)));

    assert_col_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (stb && rs && !rd && col == CW'(COLS - 1)) |=> (col == '0 && $stable(page)));

    assert_status_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (stb && !rs && rd) |=> (rdata == $past(stat_bits) && $stable(col) && $stable(hold_q)));

    assert_rmw_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (stb && rs && rd && rmw) |=> $stable(col));

    assert_strobe_gap_R12: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);
endmodule

bind dispram_port dispram_port_chk #(.COLS(COLS), .PAGES(PAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .rs        (rs),
    .rd        (rd),
    .stat_bits (stat_bits),
    .rdata     (rdata),
    .ram_we    (ram_we),
    .page      (page),
    .col       (col),
    .rmw       (rmw),
    .hold_q    (hold_q)
);

// File: tb/tb_dispram_port.sv
module tb_dispram_port;
    localparam int COLS  = 32;
    localparam int PAGES = 9;
    localparam int AW    = 9;
    localparam int NMEM  = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stb = 1'b0, rs = 1'b0, rd = 1'b0;
    logic [7:0]    wdata = '0, stat_bits = '0;
    logic [7:0]    rdata, ram_wdata, ram_rdata;
    logic [AW-1:0] ram_addr;
    logic          ram_we, ram_re;

    logic [7:0] mem [NMEM];

    int tests = 0, fails = 0;
    bit done = 0;

    logic [7:0] sm [NMEM];
    int sp = 0, sc = 0, ssave = 0;
    logic [7:0] sh = '0;
    bit srmw = 0;

    always #2 clk = ~clk;

    dispram_port #(.COLS(COLS), .PAGES(PAGES)) dut (
        .clk(clk), .rst(rst), .stb(stb), .rs(rs), .rd(rd), .wdata(wdata),
        .stat_bits(stat_bits), .rdata(rdata), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    function automatic logic [7:0] pat(input int p, input int c);
        return 8'((p * 37 + c * 5 + 1) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic a0, input logic r, input logic [7:0] d);
        @(negedge clk);
        stb = 1'b1; rs = a0; rd = r; wdata = d;
        @(negedge clk);
        stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b);
        strobe(1'b0, 1'b0, b);
        if (b == 8'hE0) begin
            if (!srmw) begin ssave = sc; srmw = 1; end
        end else if (b == 8'hEE) begin
            if (srmw) begin sc = ssave; srmw = 0; end
        end else if (b[7:4] == 4'b1011) begin
            if (int'(b[3:0]) < PAGES) sp = int'(b[3:0]);
        end else if (b[7:3] == 5'b00010) begin
            if (!srmw) sc = (int'(b[0]) << 4) | (sc & 15);
        end else if (b[7:4] == 4'b0000) begin
            if (!srmw) sc = (sc & 16) | int'(b[3:0]);
        end
    endtask

    task automatic setcol(input int c);
        cmd(8'h10 | 8'(c >> 4));
        cmd(8'(c & 15));
    endtask

    task automatic wr(input logic [7:0] d);
        strobe(1'b1, 1'b0, d);
        sm[sp * COLS + sc] = d;
        sh = d;
        sc = (sc + 1) % COLS;
    endtask

    task automatic rd_data(output logic [7:0] v);
        logic [7:0] exp;
        exp = sh;
        strobe(1'b1, 1'b1, 8'h00);
        v = rdata;
        check(v == exp, "R5 holder read", int'(v), int'(exp));
        sh = sm[sp * COLS + sc];
        if (!srmw) sc = (sc + 1) % COLS;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < NMEM; i++) begin mem[i] = '0; sm[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rdata == 8'h00, "R1 rdata", int'(rdata), 0);
        check(ram_we == 1'b0, "R1 ram_we", int'(ram_we), 0);
        rd_data(v);
        check(v == 8'h00, "R1 holder zero", int'(v), 0);

        // R4 R6: fill every page, wrap and stale dummy read
        for (int p = 0; p < PAGES; p++) begin
            cmd(8'hB0 | 8'(p));
            setcol(0);
            for (int c = 0; c < COLS; c++) wr(pat(p, c));
            rd_data(v);
            check(v == pat(p, COLS - 1), "R5 dummy stale", int'(v), int'(pat(p, COLS - 1)));
            for (int c = 0; c < COLS; c++) begin
                rd_data(v);
                check(v == pat(p, c), "R4 readback", int'(v), int'(pat(p, c)));
            end
            rd_data(v);
            check(v == pat(p, 0), "R6 wrap same page", int'(v), int'(pat(p, 0)));
        end

        // R2: out-of-range page ignored
        cmd(8'hB5);
        cmd(8'hBC);
        setcol(3);
        rd_data(v); rd_data(v);
        check(v == pat(5, 3), "R2 page ignore", int'(v), int'(pat(5, 3)));

        // R3: nibble loads independent
        cmd(8'hB6);
        cmd(8'h11); cmd(8'h0A);
        cmd(8'h05);
        rd_data(v); rd_data(v);
        check(v == pat(6, 21), "R3 low nibble only", int'(v), int'(pat(6, 21)));
        cmd(8'h10);
        rd_data(v); rd_data(v);
        check(v == pat(6, 7), "R3 high bits only", int'(v), int'(pat(6, 7)));

        // R7: status sweep leaves holder and column alone
        cmd(8'hB4); setcol(9);
        rd_data(v);
        for (int i = 0; i < 256; i++) begin
            stat_bits = 8'(i);
            strobe(1'b0, 1'b1, 8'h00);
            check(rdata == 8'(i), "R7 status", int'(rdata), i);
        end
        rd_data(v);
        check(v == pat(4, 9), "R7 holder kept", int'(v), int'(pat(4, 9)));
        rd_data(v);
        check(v == pat(4, 10), "R7 column kept", int'(v), int'(pat(4, 10)));

        // R11: unrelated commands
        setcol(7);
        cmd(8'hAF); cmd(8'h40); cmd(8'hA6); cmd(8'h81); cmd(8'h2F);
        rd_data(v); rd_data(v);
        check(v == pat(4, 7), "R11 no effect", int'(v), int'(pat(4, 7)));

        // R10: end outside mode
        setcol(12);
        cmd(8'hEE);
        rd_data(v); rd_data(v);
        check(v == pat(4, 12), "R10 end idle", int'(v), int'(pat(4, 12)));

        // R8 R9 R10: read-modify-write
        cmd(8'hB2); setcol(4);
        cmd(8'hE0);
        rd_data(v);
        rd_data(v);
        check(v == pat(2, 4), "R8 read no advance", int'(v), int'(pat(2, 4)));
        wr(8'hC1);
        rd_data(v);
        check(v == 8'hC1, "R8 holder after write", int'(v), 8'hC1);
        rd_data(v);
        check(v == pat(2, 5), "R8 write advanced", int'(v), int'(pat(2, 5)));
        cmd(8'hE0);
        wr(8'hC2);
        cmd(8'h0F); cmd(8'h11);
        wr(8'hC3);
        cmd(8'hB3);
        wr(8'hC4);
        cmd(8'hEE);
        check(sc == 4, "R10 model restore", sc, 4);
        cmd(8'hB2);
        rd_data(v); rd_data(v);
        check(v == 8'hC1, "R10 restored col", int'(v), 8'hC1);
        rd_data(v);
        check(v == 8'hC2, "R8 second enter ignored", int'(v), 8'hC2);
        rd_data(v);
        check(v == 8'hC3, "R9 colset ignored", int'(v), 8'hC3);
        cmd(8'hB3); setcol(7);
        rd_data(v); rd_data(v);
        check(v == 8'hC4, "R9 page accepted", int'(v), 8'hC4);
        check(ram_we == 1'b0, "R4 we idle", int'(ram_we), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule